// File: doc/BRIEF.md
# Two-Dimensional DCT/IDCT by Row-Column Passes

This block computes an N×N two-dimensional discrete cosine transform, forward or inverse, by running a one-dimensional transform over the rows and then over the columns of the intermediate result. An upstream source presents one N-sample row per cycle on a valid/ready interface. A row is taken on every clock edge where both `in_valid_i` and `in_ready_o` are high. When `in_valid_i` is low the block waits, and it holds no row across the gap. `in_ready_o` is low only while reset is applied. The transpose store lets the next block's rows be written while the previous block's columns are read, so a source that never pauses is never held back.

Both passes use one parameterised 1D unit design, built from N parallel inner-product lanes with one lane per output coefficient. The row results are rounded and stored in a transpose array of N² words. A further N-word staging row sits ahead of that array. The columns are then read back, one per cycle, in alternating orientation from block to block. Each column goes through the second instance of the 1D unit. The results leave as one N-coefficient vector per cycle, with a valid flag and a last flag. The mode input picks the forward matrix or its transpose. The block takes the mode with a block's first row and applies it to the whole block.

Top module: `dct2d_rc`

## Requirements
- R1: With `inv_i`=0 on the first row, output vector c holds element k at bits [16k+15:16k]. That element is the 2D forward transform coefficient at row k, column c, computed with the constants C(k,n)=round(16384·a_k·cos((2n+1)kπ/2N)). Here a_0=√(1/N) and a_k=√(2/N) for k>0. Input row r carries sample n at bits [16n+15:16n].
- R2: With `inv_i`=1 on the first row, both passes use C(n,k) in place of C(k,n), which gives the inverse 2D transform.
- R3: Each pass adds 2^13 to the signed sum of products and shifts it right arithmetically by 14. Ties therefore round upward: +0.5 becomes 1 and −0.5 becomes 0.
- R4: The result of each pass saturates to 16-bit signed: values above 32767 give 32767 and values below −32768 give −32768.
- R5: The value of `inv_i` on rows 1 to N−1 of a block has no effect on that block's outputs.
- R6: Each block yields exactly N output vectors, in column order 0 to N−1. `out_last_o` is high with the N-th vector only.
- R7: Blocks presented back to back come out as an unbroken run of output vectors, one block every N cycles. `in_ready_o` never drops during the run.
- R8: The first output vector of a block appears two clock edges after the handshake of its last row.
- R9: Cycles with `in_valid_i` low between rows change neither the data nor the order of the results.
- R10: While `rst_ni` is low, `in_ready_o` and `out_valid_o` are both low.
- R11: Once reset is released, `in_ready_o` is high by the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input row present |
| in_ready_o | output | 1 | Block can take a row |
| in_data_i | input | N·DW | Row of N signed samples, sample n at [n·DW +: DW] |
| inv_i | input | 1 | 0 forward, 1 inverse; sampled with a block's first row |
| out_valid_o | output | 1 | Output vector present |
| out_last_o | output | 1 | Final vector of a block |
| out_data_o | output | N·DW | N signed coefficients, element k at [k·DW +: DW] |

## Verification
The bench uses the default values N=4, DW=16, CW=16 and FRAC=14, so every block is four rows deep and the arithmetic is short enough to drive to its edges. With these values, a unit impulse lands exactly on a rounding tie, and full-scale constant rows overflow both passes. Because blocks are only four cycles long, the bench can stream three blocks back to back and then measure the unbroken output run and the two-edge latency directly. Mid-block mode flips and input gaps are also cheap to exercise at this size.

// File: rtl/dct2d_pkg.sv
`timescale 1ns/1ps
package dct2d_pkg;

  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic {
    XF_FWD = 1'b0,
    XF_INV = 1'b1
  } xf_mode_e;

  // cosine by range folding and a Taylor series, usable at elaboration
  function automatic real cos_r(input real ang);
    real x;
    real term;
    real acc;
    x = ang;
    while (x > PI_R) x = x - 2.0 * PI_R;
    while (x < -PI_R) x = x + 2.0 * PI_R;
    acc  = 1.0;
    term = 1.0;
    for (int i = 1; i < 30; i++) begin
      term = -term * x * x / ((2.0 * i - 1.0) * (2.0 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // square root by Newton iteration
  function automatic real sqrt_r(input real v);
    real g;
    g = (v > 1.0) ? v : 1.0;
    for (int i = 0; i < 60; i++) g = 0.5 * (g + v / g);
    return g;
  endfunction

  // fixed-point basis constant for output index k and sample index n
  function automatic int basis_q(input int npts, input int k, input int n, input int frac);
    real a;
    real v;
    a = (k == 0) ? sqrt_r(1.0 / npts) : sqrt_r(2.0 / npts);
    v = a * cos_r(((2.0 * n + 1.0) * k * PI_R) / (2.0 * npts));
    for (int i = 0; i < frac; i++) v = v * 2.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/dct2d_vip.sv
`timescale 1ns/1ps
module dct2d_vip #(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int K    = 0
) (
  input  logic [N*DW-1:0]      vec_i,
  input  logic                 inv_i,
  output logic signed [DW-1:0] coef_o
);
  localparam int PW = DW + CW;
  localparam int AW = PW + $clog2(N) + 1;
  localparam logic signed [AW-1:0] HALF = {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod [N];

  for (genvar n = 0; n < N; n++) begin : g_lane
    localparam logic signed [CW-1:0] CF = CW'(dct2d_pkg::basis_q(N, K, n, FRAC));
    localparam logic signed [CW-1:0] CI = CW'(dct2d_pkg::basis_q(N, n, K, FRAC));
    logic signed [CW-1:0] csel;
    assign csel    = inv_i ? CI : CF;
    assign prod[n] = PW'($signed(vec_i[n*DW +: DW]) * csel);
  end

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] rnd;
  logic signed [AW-1:0] shr;

  always_comb begin
    acc = '0;
    for (int n = 0; n < N; n++) acc = acc + AW'(prod[n]);
    rnd = acc + HALF;
    shr = rnd >>> FRAC;
    if (shr > MAXV)      coef_o = MAXV[DW-1:0];
    else if (shr < MINV) coef_o = MINV[DW-1:0];
    else                 coef_o = shr[DW-1:0];
  end
endmodule

// File: rtl/dct2d_1d.sv
`timescale 1ns/1ps
module dct2d_1d #(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic [N*DW-1:0] vec_i,
  input  logic            inv_i,
  output logic [N*DW-1:0] res_o
);
  for (genvar k = 0; k < N; k++) begin : g_out
    logic signed [DW-1:0] c;
    dct2d_vip #(.N(N), .DW(DW), .CW(CW), .FRAC(FRAC), .K(k)) u_vip (
      .vec_i  (vec_i),
      .inv_i  (inv_i),
      .coef_o (c)
    );
    assign res_o[k*DW +: DW] = c;
  end
endmodule

// File: rtl/dct2d_tpose.sv
`timescale 1ns/1ps
module dct2d_tpose #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            row_valid_i,
  input  logic [N*DW-1:0] row_vec_i,
  input  logic            row_inv_i,
  output logic            col_valid_o,
  output logic            col_last_o,
  output logic            col_inv_o,
  output logic [N*DW-1:0] col_vec_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  // staging row: N words ahead of the N x N array
  logic [N*DW-1:0] stg_vec;
  logic            stg_vld;
  logic            stg_inv;
  logic [DW-1:0]   mem [N][N];

  logic [IW-1:0] wr_idx;
  logic          wr_ori;
  logic          rd_act;
  logic [IW-1:0] rd_idx;
  logic          rd_ori;
  logic          rd_inv;
  logic          blk_done;

  assign blk_done = stg_vld && (wr_idx == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_vld <= 1'b0;
      stg_inv <= 1'b0;
      stg_vec <= '0;
    end else begin
      stg_vld <= row_valid_i;
      if (row_valid_i) begin
        stg_vec <= row_vec_i;
        stg_inv <= row_inv_i;
      end
    end
  end

  // array write, orientation alternates between blocks
  always_ff @(posedge clk_i) begin
    if (stg_vld) begin
      for (int j = 0; j < N; j++) begin
        if (!wr_ori) mem[wr_idx][j] <= stg_vec[j*DW +: DW];
        else         mem[j][wr_idx] <= stg_vec[j*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx <= '0;
      wr_ori <= 1'b0;
    end else if (stg_vld) begin
      wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
      if (wr_idx == LAST) wr_ori <= ~wr_ori;
    end
  end

  // column read sequencing; a completed block takes over at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act <= 1'b0;
      rd_idx <= '0;
      rd_ori <= 1'b0;
      rd_inv <= 1'b0;
    end else if (blk_done) begin
      rd_act <= 1'b1;
      rd_idx <= '0;
      rd_ori <= wr_ori;
      rd_inv <= stg_inv;
    end else if (rd_act) begin
      if (rd_idx == LAST) begin
        rd_act <= 1'b0;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      col_vec_o[i*DW +: DW] = rd_ori ? mem[rd_idx][i] : mem[i][rd_idx];
    end
  end

  assign col_valid_o = rd_act;
  assign col_last_o  = rd_act && (rd_idx == LAST);
  assign col_inv_o   = rd_inv;
endmodule

// File: rtl/dct2d_rc.sv
`timescale 1ns/1ps
module dct2d_rc #(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [N*DW-1:0] in_data_i,
  input  logic            inv_i,
  output logic            out_valid_o,
  output logic            out_last_o,
  output logic [N*DW-1:0] out_data_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic          up_q;
  logic          fire;
  logic [IW-1:0] in_cnt;
  logic          blk_inv;
  logic          row_inv;
  logic [N*DW-1:0] row_res;
  logic            col_valid;
  logic            col_last;
  logic            col_inv;
  logic [N*DW-1:0] col_vec;
  logic [N*DW-1:0] col_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  assign in_ready_o = up_q;
  assign fire       = in_valid_i && in_ready_o;

  // mode is taken with row 0 and held for the rest of the block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= '0;
      blk_inv <= dct2d_pkg::XF_FWD;
    end else if (fire) begin
      in_cnt <= (in_cnt == LAST) ? '0 : in_cnt + 1'b1;
      if (in_cnt == '0) blk_inv <= inv_i;
    end
  end

  assign row_inv = (in_cnt == '0) ? inv_i : blk_inv;

  dct2d_1d #(.N(N), .DW(DW), .CW(CW), .FRAC(FRAC)) u_row (
    .vec_i (in_data_i),
    .inv_i (row_inv),
    .res_o (row_res)
  );

  dct2d_tpose #(.N(N), .DW(DW)) u_tp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_valid_i (fire),
    .row_vec_i   (row_res),
    .row_inv_i   (row_inv),
    .col_valid_o (col_valid),
    .col_last_o  (col_last),
    .col_inv_o   (col_inv),
    .col_vec_o   (col_vec)
  );

  dct2d_1d #(.N(N), .DW(DW), .CW(CW), .FRAC(FRAC)) u_col (
    .vec_i (col_vec),
    .inv_i (col_inv),
    .res_o (col_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= col_valid;
      out_last_o  <= col_valid && col_last;
      if (col_valid) out_data_o <= col_res;
    end
  end
endmodule

// File: rtl/dct2d_rc_chk.sv
`timescale 1ns/1ps
module dct2d_rc_chk #(
  parameter int N = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic out_last_o
);
  localparam int CNW = $clog2(N) + 1;
  localparam int PNW = $clog2(4 * N + 4);

  logic [CNW-1:0] vec_cnt;
  logic [PNW-1:0] pend;
  logic           acc_row;

  assign acc_row = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_cnt <= '0;
      pend    <= '0;
    end else begin
      if (out_valid_o) vec_cnt <= (vec_cnt == CNW'(N - 1)) ? '0 : vec_cnt + 1'b1;
      case ({acc_row, out_valid_o})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R6

  AST_LAST_ON_NTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (vec_cnt == CNW'(N - 1)))); // R6

  AST_NO_PHANTOM_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (pend != '0)); // R6

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend <= PNW'(2 * N + 1)); // R7

  AST_QUIET_IN_RESET: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (!in_ready_o && !out_valid_o)); // R10
endmodule

bind dct2d_rc dct2d_rc_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o)
);

// File: tb/dct2d_rc_bench.sv
`timescale 1ns/1ps
module dct2d_rc_bench;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam real PI_B = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic [N*DW-1:0] in_data;
  logic inv_in;
  logic out_valid;
  logic out_last;
  logic [N*DW-1:0] out_data;

  always #2.5 clk = ~clk;

  dct2d_rc #(.N(N), .DW(DW), .CW(16), .FRAC(14)) u_dct2d_rc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .inv_i       (inv_in),
    .out_valid_o (out_valid),
    .out_last_o  (out_last),
    .out_data_o  (out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int stalls   = 0;
  int run_len  = 0;
  int last_run = 0;
  bit done     = 1'b0;

  int blk [N][N];
  logic [N*DW-1:0] exp_q [$];
  bit              exp_last_q [$];
  string           exp_tag_q [$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint basis(input int inv, input int k, input int n);
    int a;
    int b;
    real s;
    real v;
    a = inv ? n : k;
    b = inv ? k : n;
    s = (a == 0) ? $sqrt(1.0 / N) : $sqrt(2.0 / N);
    v = s * $cos(PI_B * (2.0 * b + 1.0) * a / (2.0 * N)) * 16384.0;
    if (v < 0.0) return -longint'($rtoi(0.5 - v));
    return longint'($rtoi(v + 0.5));
  endfunction

  function automatic longint rsat(input longint s);
    longint r;
    r = (s + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic push_block(input int inv, input string tag);
    longint y [N][N];
    longint s;
    logic [N*DW-1:0] v;
    for (int r = 0; r < N; r++)
      for (int k = 0; k < N; k++) begin
        s = 0;
        for (int n = 0; n < N; n++) s += basis(inv, k, n) * blk[r][n];
        y[r][k] = rsat(s);
      end
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < N; k++) begin
        s = 0;
        for (int i = 0; i < N; i++) s += basis(inv, k, i) * y[i][c];
        v[k*DW +: DW] = DW'(rsat(s));
      end
      exp_q.push_back(v);
      exp_last_q.push_back(c == N - 1);
      exp_tag_q.push_back(tag);
    end
  endtask

  function automatic logic [N*DW-1:0] pack_row(input int r);
    logic [N*DW-1:0] v;
    for (int n = 0; n < N; n++) v[n*DW +: DW] = DW'(blk[r][n]);
    return v;
  endfunction

  task automatic fill_rand(input int span);
    for (int r = 0; r < N; r++)
      for (int n = 0; n < N; n++) blk[r][n] = int'($urandom_range(2 * span)) - span;
  endtask

  task automatic fill_const(input int val);
    for (int r = 0; r < N; r++)
      for (int n = 0; n < N; n++) blk[r][n] = val;
  endtask

  // driver: model first, then rows; flip toggles the mode on rows after row 0
  task automatic send_block(input int inv, input bit flip, input int gap, input string tag);
    bit rdy;
    push_block(inv, tag);
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pack_row(r);
      inv_in   = (r == 0) ? inv[0] : (flip ? ~inv[0] : inv[0]);
      forever begin
        rdy = in_ready;
        @(posedge clk);
        if (rdy) break;
        stalls++;
        @(negedge clk);
      end
      if (gap > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        inv_in   = ~inv_in;
        in_data  = ~in_data;
        repeat (gap - 1) @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: compare each produced vector with the scoreboard head
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_valid) begin
        run_len++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected vector", 1, 0);
        end else begin
          logic [N*DW-1:0] e;
          bit el;
          string t;
          e  = exp_q.pop_front();
          el = exp_last_q.pop_front();
          t  = exp_tag_q.pop_front();
          for (int k = 0; k < N; k++)
            check(out_data[k*DW +: DW] == e[k*DW +: DW], t,
                  longint'($signed(out_data[k*DW +: DW])), longint'($signed(e[k*DW +: DW])));
          check(out_last == el, "R6 last flag", longint'(out_last), longint'(el));
        end
      end else if (run_len > 0) begin
        last_run = run_len;
        run_len  = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    inv_in   = 1'b0;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R10 ready in reset", longint'(in_ready), 0);
    check(out_valid == 1'b0, "R10 valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready after reset", longint'(in_ready), 1);

    fill_rand(2000); send_block(0, 0, 0, "R1 forward random");
    fill_rand(2000); send_block(0, 0, 0, "R1 forward random");
    idle(8);
    fill_rand(2000); send_block(1, 0, 0, "R2 inverse random");
    idle(8);
    fill_const(0); blk[0][0] = 1; blk[2][1] = -1;
    send_block(0, 0, 0, "R3 rounding ties");
    idle(8);
    fill_const(32767);  send_block(0, 0, 0, "R4 positive saturation");
    fill_const(-32768); send_block(0, 0, 0, "R4 negative saturation");
    fill_const(32767);  send_block(1, 0, 0, "R4 inverse saturation");
    idle(8);
    fill_rand(3000); send_block(0, 1, 0, "R5 mode flip ignored fwd");
    fill_rand(3000); send_block(1, 1, 0, "R5 mode flip ignored inv");
    idle(8);
    fill_rand(2000); send_block(1, 0, 2, "R9 input gaps");
    fill_rand(2000); send_block(0, 0, 3, "R9 input gaps");
    idle(10);

    fill_rand(1000); send_block(0, 0, 0, "R8 latency block");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R8 no output one edge after", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 no output at first edge", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8 output at second edge", longint'(out_valid), 1);
    idle(10);

    stalls = 0;
    fill_rand(2000); send_block(0, 0, 0, "R7 burst");
    fill_rand(2000); send_block(1, 0, 0, "R7 burst");
    fill_rand(2000); send_block(0, 0, 0, "R7 burst");
    idle(20);
    check(last_run == 3 * N, "R7 contiguous output run", longint'(last_run), longint'(3 * N));
    check(stalls == 0, "R7 no ready drop", longint'(stalls), 0);
    check(exp_q.size() == 0, "R6 all vectors delivered", longint'(exp_q.size()), 0);
    done = 1'b1;
    report();
  end
endmodule